// File: doc/BRIEF.md
# Rotating Temporary Register Renamer

This block sits in the issue stage of an out-of-order floating-point pipeline and removes name dependencies (write-after-write and write-after-read) by giving each written architectural register a fresh temporary register. Temporaries come from a circular pool of 64, handed out strictly in rotation. The block keeps one mapping entry per architectural register, pointing at the temporary that holds its newest value.

Each cycle one instruction may be offered. It has two source register numbers and an optional destination. One cycle after acceptance the renamed instruction appears at the outputs. A source with a mapping is replaced by its temporary, and one without a mapping passes through unchanged. Each output operand has a flag that tells a temporary number from an architectural number. The destination, when present, is replaced by the temporary at the head of the rotation. When a downstream stage no longer needs a temporary, it returns it on a release port. Any mapping that still points at that temporary is dropped. If the temporary at the head of the rotation is still in use, the block holds its ready output low and accepts nothing until that temporary is returned.

Top module: `trename_top`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, no architectural register is mapped, and the first destination allocated is T0.
- R2: Accepted destinations receive temporaries in strictly increasing order, one per destination, wrapping from T63 back to T0.
- R3: A source whose architectural register is mapped is output as the mapped temporary number with its flag set to 1. An unmapped source is output as its architectural number, zero-extended, with its flag 0.
- R4: Source lookups use the mappings as they were before the instruction's own destination update, so an instruction that reads and writes the same register sees the earlier temporary.
- R5: An instruction is accepted when inValid and inReady are both 1. Its renamed form appears with outValid 1 on the next cycle, and outValid is 0 after any cycle without acceptance.
- R6: An accepted instruction with inDstEn 0 consumes no temporary and leaves all mappings unchanged. It is output with outDstEn 0 and outDst 0.
- R7: inReady is 0 whenever the temporary at the head of the rotation is still live. An instruction offered while inReady is 0 is dropped and produces no output.
- R8: A temporary is live from its allocation until it is released. Releasing the head temporary raises inReady on the next cycle.
- R9: Releasing a temporary removes every mapping that points to it, so later reads of that architectural register come out unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is offered |
| inReady | output | 1 | The block can accept an instruction this cycle |
| inSrcA | input | 5 | First source architectural register |
| inSrcB | input | 5 | Second source architectural register |
| inDstEn | input | 1 | The instruction writes a destination |
| inDst | input | 5 | Destination architectural register |
| relValid | input | 1 | A temporary is returned this cycle |
| relTag | input | 6 | Number of the temporary returned |
| outValid | output | 1 | Renamed instruction valid |
| outSrcA | output | 6 | First source, temporary or architectural number |
| outSrcATemp | output | 1 | 1 when outSrcA is a temporary number |
| outSrcB | output | 6 | Second source, temporary or architectural number |
| outSrcBTemp | output | 1 | 1 when outSrcB is a temporary number |
| outDstEn | output | 1 | Renamed instruction has a destination |
| outDst | output | 6 | Allocated destination temporary |

## Verification
The hardest state to reach is the wrapped pool. Here the rotation has gone all the way round and found its next temporary still live, so the block must stall, and then it must resume once that temporary is returned. To get there, the stimulus first runs a short table of dependent instructions and releases only T0. It then issues enough further destinations to allocate T6 through T63. The next allocation lands on the freed T0, and the one after it meets the still-live T1. At that point the stimulus offers an instruction while ready is low and checks that nothing comes out. It then releases T1 and checks that the next destination receives T1.

// File: rtl/trename_pkg.sv
package trename_pkg;
  parameter int ARCH_REGS = 32;
  parameter int POOL_SIZE = 64;
  localparam int ARCH_W = $clog2(ARCH_REGS);
  localparam int TAG_W  = $clog2(POOL_SIZE);
  localparam int OPND_W = (TAG_W > ARCH_W) ? TAG_W : ARCH_W;

  typedef logic [ARCH_W-1:0] archT;
  typedef logic [TAG_W-1:0]  tagT;
  typedef logic [OPND_W-1:0] opndT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic alloc;
    tagT  allocTag;
    logic rel;
    tagT  relTag;
  } ctrlStrobeT;
endpackage

// File: rtl/trename_ctrl.sv
module trename_ctrl
  import trename_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inDstEn,
  input  logic       relValid,
  input  tagT        relTag,
  output logic       inReady,
  output ctrlStrobeT strobes
);
  tagT headPtr;
  logic [POOL_SIZE-1:0] liveBits;

  // head temporary must be free before anything is accepted
  assign inReady = !liveBits[headPtr];

  always_comb begin
    strobes.accept   = inValid && inReady;
    strobes.alloc    = inValid && inReady && inDstEn;
    strobes.allocTag = headPtr;
    strobes.rel      = relValid;
    strobes.relTag   = relTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
    end else if (strobes.alloc) begin
      headPtr <= (headPtr == tagT'(POOL_SIZE - 1)) ? '0 : headPtr + tagT'(1);
    end
  end

  // one live flag per temporary; allocation set wins over release clear
  for (genvar t = 0; t < POOL_SIZE; t++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveBits[t] <= 1'b0;
      end else if (strobes.alloc && headPtr == tagT'(t)) begin
        liveBits[t] <= 1'b1;
      end else if (strobes.rel && relTag == tagT'(t)) begin
        liveBits[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trename_datapath.sv
module trename_datapath
  import trename_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strobes,
  input  archT       inSrcA,
  input  archT       inSrcB,
  input  logic       inDstEn,
  input  archT       inDst,
  output logic       outValid,
  output opndT       outSrcA,
  output logic       outSrcATemp,
  output opndT       outSrcB,
  output logic       outSrcBTemp,
  output logic       outDstEn,
  output tagT        outDst
);
  logic [ARCH_REGS-1:0] mapValid;
  tagT                  mapTag [ARCH_REGS];

  // per architectural register mapping entry
  for (genvar r = 0; r < ARCH_REGS; r++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapValid[r] <= 1'b0;
        mapTag[r]   <= '0;
      end else if (strobes.alloc && inDst == archT'(r)) begin
        mapValid[r] <= 1'b1;
        mapTag[r]   <= strobes.allocTag;
      end else if (strobes.rel && mapValid[r] && mapTag[r] == strobes.relTag) begin
        mapValid[r] <= 1'b0;
      end
    end
  end

  // lookups read the table before this cycle's update
  opndT nextSrcA, nextSrcB;
  logic nextATemp, nextBTemp;

  always_comb begin
    nextATemp = mapValid[inSrcA];
    nextBTemp = mapValid[inSrcB];
    nextSrcA  = nextATemp ? opndT'(mapTag[inSrcA]) : opndT'(inSrcA);
    nextSrcB  = nextBTemp ? opndT'(mapTag[inSrcB]) : opndT'(inSrcB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outSrcA     <= '0;
      outSrcATemp <= 1'b0;
      outSrcB     <= '0;
      outSrcBTemp <= 1'b0;
      outDstEn    <= 1'b0;
      outDst      <= '0;
    end else begin
      outValid <= strobes.accept;
      if (strobes.accept) begin
        outSrcA     <= nextSrcA;
        outSrcATemp <= nextATemp;
        outSrcB     <= nextSrcB;
        outSrcBTemp <= nextBTemp;
        outDstEn    <= inDstEn;
        outDst      <= inDstEn ? strobes.allocTag : '0;
      end
    end
  end
endmodule

// File: rtl/trename_top.sv
module trename_top
  import trename_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ARCH_W-1:0] inSrcA,
  input  logic [ARCH_W-1:0] inSrcB,
  input  logic              inDstEn,
  input  logic [ARCH_W-1:0] inDst,
  input  logic              relValid,
  input  logic [TAG_W-1:0]  relTag,
  output logic              outValid,
  output logic [OPND_W-1:0] outSrcA,
  output logic              outSrcATemp,
  output logic [OPND_W-1:0] outSrcB,
  output logic              outSrcBTemp,
  output logic              outDstEn,
  output logic [TAG_W-1:0]  outDst
);
  ctrlStrobeT strobes;

  trename_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDstEn(inDstEn),
    .relValid(relValid), .relTag(relTag), .inReady(inReady), .strobes(strobes)
  );

  trename_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDstEn(inDstEn), .inDst(inDst),
    .outValid(outValid), .outSrcA(outSrcA), .outSrcATemp(outSrcATemp),
    .outSrcB(outSrcB), .outSrcBTemp(outSrcBTemp),
    .outDstEn(outDstEn), .outDst(outDst)
  );
endmodule

// File: rtl/trename_chk.sv
module trename_chk
  import trename_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              relValid,
  input logic              outValid,
  input logic [OPND_W-1:0] outSrcA,
  input logic              outSrcATemp,
  input logic [OPND_W-1:0] outSrcB,
  input logic              outSrcBTemp,
  input logic              outDstEn,
  input logic [TAG_W-1:0]  outDst
);
  logic [TAG_W-1:0] expTag;

  always_ff @(posedge clk) begin
    if (!rstN) expTag <= '0;
    else if (outValid && outDstEn)
      expTag <= (expTag == TAG_W'(POOL_SIZE - 1)) ? '0 : expTag + TAG_W'(1);
  end

  assert_accept_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_idle_no_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  assert_stall_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> !outValid);

  assert_rotation_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDstEn) |-> outDst == expTag);

  assert_ready_by_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(inReady) && inReady) |-> $past(relValid));

  assert_arch_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSrcATemp) |-> outSrcA < OPND_W'(ARCH_REGS));

  assert_arch_range_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSrcBTemp) |-> outSrcB < OPND_W'(ARCH_REGS));

  assert_nodst_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDstEn) |-> outDst == '0);
endmodule

bind trename_top trename_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .relValid(relValid), .outValid(outValid), .outSrcA(outSrcA),
  .outSrcATemp(outSrcATemp), .outSrcB(outSrcB), .outSrcBTemp(outSrcBTemp),
  .outDstEn(outDstEn), .outDst(outDst)
);

// File: tb/trename_top_tb_top.sv
module trename_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inDstEn = 1'b0, relValid = 1'b0;
  logic [4:0] inSrcA = '0, inSrcB = '0, inDst = '0;
  logic [5:0] relTag = '0;
  logic inReady, outValid, outSrcATemp, outSrcBTemp, outDstEn;
  logic [5:0] outSrcA, outSrcB, outDst;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  trename_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDstEn(inDstEn), .inDst(inDst),
    .relValid(relValid), .relTag(relTag), .outValid(outValid),
    .outSrcA(outSrcA), .outSrcATemp(outSrcATemp), .outSrcB(outSrcB),
    .outSrcBTemp(outSrcBTemp), .outDstEn(outDstEn), .outDst(outDst)
  );

  typedef struct packed {
    logic dEn; logic [4:0] d; logic [4:0] a; logic [4:0] b;
    logic [5:0] eA; logic eAT; logic [5:0] eB; logic eBT; logic [5:0] eD;
  } vecT;

  // dEn, dst, srcA, srcB, expA, expATemp, expB, expBTemp, expDst
  localparam vecT VECS [7] = '{
    '{1'b1, 5'd4, 5'd1, 5'd2, 6'd1, 1'b0, 6'd2, 1'b0, 6'd0},  // R1 R3
    '{1'b1, 5'd2, 5'd0, 5'd4, 6'd0, 1'b0, 6'd0, 1'b1, 6'd1},  // R2 R3
    '{1'b1, 5'd8, 5'd4, 5'd2, 6'd0, 1'b1, 6'd1, 1'b1, 6'd2},
    '{1'b0, 5'd0, 5'd8, 5'd3, 6'd2, 1'b1, 6'd3, 1'b0, 6'd0},  // R6 no dst
    '{1'b1, 5'd8, 5'd8, 5'd6, 6'd2, 1'b1, 6'd6, 1'b0, 6'd3},  // R4 R6
    '{1'b1, 5'd6, 5'd0, 5'd4, 6'd0, 1'b0, 6'd0, 1'b1, 6'd4},
    '{1'b1, 5'd0, 5'd6, 5'd8, 6'd4, 1'b1, 6'd3, 1'b1, 6'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic dEn, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    inValid = 1'b1; inDstEn = dEn; inDst = d; inSrcA = a; inSrcB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic release_tag(input logic [5:0] t);
    @(negedge clk);
    relValid = 1'b1; relTag = t;
    @(negedge clk);
    relValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 inReady", int'(inReady), 1);

    foreach (VECS[i]) begin
      issue(VECS[i].dEn, VECS[i].d, VECS[i].a, VECS[i].b);
      check("R5 outValid", int'(outValid), 1);
      check("R3 srcA", int'(outSrcA), int'(VECS[i].eA));
      check("R3 srcA flag", int'(outSrcATemp), int'(VECS[i].eAT));
      check("R3 srcB", int'(outSrcB), int'(VECS[i].eB));
      check("R3 srcB flag", int'(outSrcBTemp), int'(VECS[i].eBT));
      check("R6 dstEn", int'(outDstEn), int'(VECS[i].dEn));
      check("R2 dst", int'(outDst), int'(VECS[i].eD));
      @(negedge clk);
      check("R5 outValid drop", int'(outValid), 0);
    end

    // R9: releasing T0 unmaps register 4
    release_tag(6'd0);
    issue(1'b1, 5'd10, 5'd4, 5'd2);
    check("R9 srcA unmapped", int'(outSrcA), 4);
    check("R9 srcA flag", int'(outSrcATemp), 0);
    check("R3 srcB still mapped", int'(outSrcB), 1);
    check("R2 dst T6", int'(outDst), 6);

    // allocate T7..T63
    for (int k = 7; k < 64; k++) begin
      issue(1'b1, 5'd10, 5'd31, 5'd31);
      check("R2 rotation", int'(outDst), k);
    end
    // wrap back to freed T0
    issue(1'b1, 5'd11, 5'd10, 5'd0);
    check("R2 wrap dst", int'(outDst), 0);
    check("R4 srcA latest", int'(outSrcA), 63);

    // T1 still live: stall
    @(negedge clk);
    check("R7 ready low", int'(inReady), 0);
    inValid = 1'b1; inDstEn = 1'b1; inDst = 5'd12;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 dropped", int'(outValid), 0);

    release_tag(6'd1);
    check("R8 ready back", int'(inReady), 1);
    issue(1'b1, 5'd12, 5'd2, 5'd11);
    check("R8 dst T1", int'(outDst), 1);
    check("R9 reg2 unmapped", int'(outSrcATemp), 0);
    check("R3 reg11 mapped", int'(outSrcB), 0);
    check("R3 reg11 flag", int'(outSrcBTemp), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule